// File: doc/BRIEF.md
# Clocked Host Bridge to an Asynchronous 16-bit Static RAM

This block lets a synchronous host issue single word or single byte reads and writes to an external asynchronous static RAM of 131072 sixteen-bit words. The host hands over one request at a time on a valid/ready channel. Each request carries a direction flag, a 17-bit word address, write data and a two-bit byte mask. The bridge converts the request into the memory's level-sensitive control sequence. That sequence uses a chip-enable pair of opposite polarity, an output enable, a write strobe, one select per byte lane and a shared tri-state data bus. It then returns a one-cycle response pulse that carries read data.

All memory timing comes from counting clock cycles. The clock period and the memory's read cycle, output-enable access, write-pulse width, write cycle and write-to-high-impedance times are parameters in nanoseconds. Each count is the ceiling of the time divided by the period, with a minimum of one. Back-pressure works only in the request direction. `req_ready` is high only while the bridge is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. The response channel has no ready: the host must take `rsp_valid` in the cycle in which it is high.

Top module: `sram_lane_bridge`

## Requirements
- R1: `req_ready` is high only when the bridge is idle. A request is taken, with all of its fields captured, on an edge where `req_valid` and `req_ready` are both high, and `req_ready` is low for the rest of that access.
- R2: The memory is selected (`mem_ce_n`=0 and `mem_ce`=1) only during an access with a non-zero mask. In every other cycle `mem_ce_n`=1 and `mem_ce`=0, and a lane select is never active while the memory is unselected.
- R3: A request whose mask is 0 never selects the memory or a lane. Its response arrives 1 cycle after acceptance, with `rsp_rdata`=0.
- R4: Mask bit 0 drives `mem_losel_n` low (data bits 7:0) and mask bit 1 drives `mem_hisel_n` low (data bits 15:8), for every selected cycle of the access.
- R5: A read holds `mem_outen_n` low and `mem_wstb_n` high for exactly N_RD cycles, where N_RD = cycles(max(T_RC_NS, T_OE_NS)). The bridge drives no data lane while `mem_outen_n` is low.
- R6: Read data is captured on the last cycle in which `mem_outen_n` is low. Lanes enabled by the mask carry the memory data, and disabled lanes return 0.
- R7: A write takes 1 setup cycle (data driven, `mem_wstb_n` high), then N_WP cycles with `mem_wstb_n` low, then 1 hold cycle with `mem_wstb_n` high. N_WP = max(cycles(T_WP_NS), cycles(T_WHZ_NS), cycles(T_WC_NS)-2). `mem_outen_n` stays high, and address and lane selects stay stable while the strobe is low.
- R8: A byte write changes only the lane its mask enables. The other byte of the word keeps its value.
- R9: After a read, one turnaround cycle follows in which the memory is unselected, `mem_outen_n` is high and `req_ready` is low. `req_ready` rises in the cycle after that.
- R10: Every access yields exactly one `rsp_valid` pulse of one cycle. A read's pulse is due N_RD+1 cycles after acceptance and a write's pulse N_WP+2 cycles after acceptance. `rsp_rdata` is 0 for writes.
- R11: The memory sees output enable low for at least cycles(T_OE_NS) cycles and the write strobe low for at least cycles(T_WP_NS) cycles, where cycles(t) = ceil(t / CLK_PERIOD_NS), minimum 1.
- R12: While reset is held and just after it, the memory is unselected, both strobes and both lane selects are high, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Bridge idle, request taken this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte mask, bit 0 = low byte, bit 1 = high byte |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_ce | output | 1 | Active-high chip enable |
| mem_outen_n | output | 1 | Active-low output enable |
| mem_wstb_n | output | 1 | Active-low write strobe |
| mem_hisel_n | output | 1 | Active-low select of data bits 15:8 |
| mem_losel_n | output | 1 | Active-low select of data bits 7:0 |
| mem_a | output | 17 | Memory address |
| mem_d | inout | 16 | Tri-state data bus |

## Verification
Every count starts at the clock edge that accepts the request. The response pulse is due 1 cycle later for an empty mask, N_RD+1 cycles later for a read and N_WP+2 cycles later for a write. The ready flag returns one cycle after the pulse. The bench drives requests at falling edges and counts falling edges after acceptance until the pulse appears. It then compares that count with the due cycle. Over the same window it tallies the cycles in which the memory is selected, output enable is low and the write strobe is low. It compares read data in the pulse cycle, and its memory model checks strobe widths when each strobe releases.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_TURN,
    ST_WSET,
    ST_WPUL,
    ST_WHOLD
  } bridge_state_t;

  // Whole clock cycles that cover a time in ns, never fewer than one.
  function automatic int cycles_of(input int t_ns, input int period_ns);
    int c;
    c = (t_ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign last = (cnt == '0);
endmodule

// File: rtl/sram_lane_map.sv
module sram_lane_map #(
  parameter int LANES = 2
) (
  input  logic               active,
  input  logic               writing,
  input  logic [LANES-1:0]   be,
  output logic [LANES-1:0]   sel_n,
  output logic [LANES-1:0]   drv,
  output logic [8*LANES-1:0] mask
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign sel_n[g]         = ~(active & be[g]);
    assign drv[g]           = writing & be[g];
    assign mask[8*g +: 8]   = {8{be[g]}};
  end
endmodule

// File: rtl/sram_lane_bridge.sv
module sram_lane_bridge
  import sram_bridge_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_NS = 4,
  parameter int T_RC_NS       = 55,
  parameter int T_OE_NS       = 25,
  parameter int T_WP_NS       = 40,
  parameter int T_WC_NS       = 55,
  parameter int T_WHZ_NS      = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_outen_n,
  output logic              mem_wstb_n,
  output logic              mem_hisel_n,
  output logic              mem_losel_n,
  output logic [ADDR_W-1:0] mem_a,
  inout  wire  [DATA_W-1:0] mem_d
);
  localparam int LANES = DATA_W / 8;
  localparam int N_RD  = cycles_of(max2(T_RC_NS, T_OE_NS), CLK_PERIOD_NS);
  localparam int N_WP  = max2(max2(cycles_of(T_WP_NS, CLK_PERIOD_NS),
                                   cycles_of(T_WHZ_NS, CLK_PERIOD_NS)),
                              cycles_of(T_WC_NS, CLK_PERIOD_NS) - 2);
  localparam int CW    = $clog2(max2(N_RD, N_WP) + 1);

  bridge_state_t       state, nxt;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [LANES-1:0]    be_q;
  logic [DATA_W-1:0]   rdata_q;
  logic                rsp_q;
  logic                tm_load, tm_last;
  logic [CW-1:0]       tm_val;
  logic                active, writing;
  logic [LANES-1:0]    lane_sel_n, lane_drv;
  logic [DATA_W-1:0]   lane_mask;

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tm_load), .load_val(tm_val), .last(tm_last)
  );

  always_comb begin
    nxt     = state;
    tm_load = 1'b0;
    tm_val  = '0;
    unique case (state)
      ST_IDLE: if (req_valid) begin
        if (req_be == '0)   nxt = ST_TURN;
        else if (req_write) nxt = ST_WSET;
        else begin
          nxt     = ST_RD;
          tm_load = 1'b1;
          tm_val  = CW'(N_RD - 1);
        end
      end
      ST_RD:   if (tm_last) nxt = ST_TURN;
      ST_TURN: nxt = ST_IDLE;
      ST_WSET: begin
        nxt     = ST_WPUL;
        tm_load = 1'b1;
        tm_val  = CW'(N_WP - 1);
      end
      ST_WPUL: if (tm_last) nxt = ST_WHOLD;
      ST_WHOLD: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      state <= nxt;
      rsp_q <= (nxt == ST_TURN) || (nxt == ST_WHOLD);
      if (state == ST_IDLE && req_valid) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        be_q    <= req_be;
        rdata_q <= '0;
      end
      if (state == ST_RD && tm_last)
        rdata_q <= mem_d & lane_mask;
    end
  end

  assign writing = (state == ST_WSET) || (state == ST_WPUL) || (state == ST_WHOLD);
  assign active  = writing || (state == ST_RD);

  sram_lane_map #(.LANES(LANES)) u_lanes (
    .active(active), .writing(writing), .be(be_q),
    .sel_n(lane_sel_n), .drv(lane_drv), .mask(lane_mask)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_dq
    assign mem_d[8*g +: 8] = lane_drv[g] ? wdata_q[8*g +: 8] : 8'bz;
  end

  assign req_ready   = (state == ST_IDLE);
  assign rsp_valid   = rsp_q;
  assign rsp_rdata   = rdata_q;
  assign mem_ce_n    = ~active;
  assign mem_ce      = active;
  assign mem_outen_n = ~(state == ST_RD);
  assign mem_wstb_n  = ~(state == ST_WPUL);
  assign mem_losel_n = lane_sel_n[0];
  assign mem_hisel_n = lane_sel_n[LANES-1];
  assign mem_a       = addr_q;
endmodule

// File: rtl/sram_bridge_chk.sv
module sram_bridge_chk #(
  parameter int ADDR_W = 17,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_be,
  input logic              rsp_valid,
  input logic              mem_ce_n,
  input logic              mem_ce,
  input logic              mem_outen_n,
  input logic              mem_wstb_n,
  input logic              mem_hisel_n,
  input logic              mem_losel_n,
  input logic [ADDR_W-1:0] mem_a,
  input logic [LANES-1:0]  lane_drv
);
  // R1: while taking requests, the memory is idle
  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && !mem_ce && mem_outen_n && mem_wstb_n));

  // R2: a lane select needs the memory selected
  p_lane_needs_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_losel_n || !mem_hisel_n) |-> (!mem_ce_n && mem_ce));

  // R3: empty mask leaves the memory alone and answers next cycle
  p_zero_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_be == 2'b00)
      |=> (rsp_valid && mem_ce_n && mem_hisel_n && mem_losel_n));

  // R5: no data lane driven while the memory may drive
  p_no_drive_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_outen_n |-> (lane_drv == '0));

  // R7: output enable stays high during the write strobe
  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wstb_n |-> mem_outen_n);

  // R7: address and lane selects steady through the strobe
  p_write_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wstb_n && $past(!mem_wstb_n))
      |-> ($stable(mem_a) && $stable(mem_hisel_n) && $stable(mem_losel_n)));

  // R9: the cycle after a read ends is a turnaround cycle
  p_turnaround_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_outen_n) |-> (!req_ready && mem_ce_n));

  // R10: response is a single-cycle pulse
  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind sram_lane_bridge sram_bridge_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_be(req_be), .rsp_valid(rsp_valid), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
  .mem_outen_n(mem_outen_n), .mem_wstb_n(mem_wstb_n), .mem_hisel_n(mem_hisel_n),
  .mem_losel_n(mem_losel_n), .mem_a(mem_a), .lane_drv(lane_drv)
);

// File: tb/sram_lane_bridge_test.sv
module sram_lane_bridge_test;
  localparam int PER = 4;
  localparam int TRC = 55, TOE = 25, TWP = 40, TWC = 55, TWHZ = 20;

  function automatic int cyc(input int t);
    int c;
    c = (t + PER - 1) / PER;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_RD = cyc(mx(TRC, TOE));
  localparam int E_WP = mx(mx(cyc(TWP), cyc(TWHZ)), cyc(TWC) - 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic        mem_ce_n, mem_ce, mem_outen_n, mem_wstb_n, mem_hisel_n, mem_losel_n;
  logic [16:0] mem_a;
  wire  [15:0] mem_d;

  sram_lane_bridge #(.CLK_PERIOD_NS(PER), .T_RC_NS(TRC), .T_OE_NS(TOE),
    .T_WP_NS(TWP), .T_WC_NS(TWC), .T_WHZ_NS(TWHZ)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_outen_n(mem_outen_n),
    .mem_wstb_n(mem_wstb_n), .mem_hisel_n(mem_hisel_n), .mem_losel_n(mem_losel_n),
    .mem_a(mem_a), .mem_d(mem_d));

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural memory: selection truth table, lane gating, strobe widths.
  logic [15:0] store  [int];
  logic [15:0] shadow [int];
  logic [15:0] rd_word = '0;
  logic        sel;
  assign sel = !mem_ce_n && mem_ce;
  assign mem_d[7:0]  = (sel && !mem_outen_n && mem_wstb_n && !mem_losel_n) ? rd_word[7:0]  : 8'bz;
  assign mem_d[15:8] = (sel && !mem_outen_n && mem_wstb_n && !mem_hisel_n) ? rd_word[15:8] : 8'bz;

  int oe_run = 0, we_run = 0;
  logic pend = 1'b0, p_lo = 1'b0, p_hi = 1'b0;
  logic [16:0] p_addr = '0;
  logic [15:0] p_data = '0;
  always @(posedge clk) begin
    rd_word <= store.exists(int'(mem_a)) ? store[int'(mem_a)] : 16'h0;
    if (sel && !mem_outen_n) oe_run++;
    else if (oe_run != 0) begin
      chk(oe_run >= cyc(TOE), "R11 output enable width", oe_run, cyc(TOE));
      oe_run = 0;
    end
    if (sel && !mem_wstb_n) begin
      we_run++;
      pend   = 1'b1;
      p_addr = mem_a;
      p_data = mem_d;
      p_lo   = !mem_losel_n;
      p_hi   = !mem_hisel_n;
    end else if (pend) begin
      chk(we_run >= cyc(TWP), "R11 write strobe width", we_run, cyc(TWP));
      begin
        logic [15:0] w;
        w = store.exists(int'(p_addr)) ? store[int'(p_addr)] : 16'h0;
        if (p_lo) w[7:0]  = p_data[7:0];
        if (p_hi) w[15:8] = p_data[15:8];
        store[int'(p_addr)] = w;
      end
      pend   = 1'b0;
      we_run = 0;
    end
  end

  int lat, n_sel, n_oe, n_we, n_strb;
  logic rdy_at_rsp, ce_at_rsp;
  logic [15:0] got;

  task automatic do_op(input logic wr, input logic [1:0] be, input logic [16:0] a,
                       input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_be = be; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
    lat = 0; n_sel = 0; n_oe = 0; n_we = 0; n_strb = 0;
    do begin
      @(negedge clk);
      lat++;
      if (!mem_ce_n) n_sel++;
      if (!mem_outen_n) n_oe++;
      if (!mem_wstb_n) n_we++;
      if (!mem_ce_n && ((mem_losel_n != !be[0]) || (mem_hisel_n != !be[1]))) n_strb++;
    end while (!rsp_valid && lat < 200);
    got = rsp_rdata;
    rdy_at_rsp = req_ready;
    ce_at_rsp  = mem_ce_n;
    if (wr && be != 2'b00) begin
      logic [15:0] w;
      w = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
      if (be[0]) w[7:0]  = d[7:0];
      if (be[1]) w[15:8] = d[15:8];
      shadow[int'(a)] = w;
    end
  endtask

  task automatic check_op(input logic wr, input logic [1:0] be, input logic [15:0] exp);
    if (be == 2'b00) begin
      chk(lat == 1, "R3 empty-mask latency", lat, 1);
      chk(n_sel == 0, "R3 empty-mask never selects", n_sel, 0);
      chk(got == 16'h0, "R3 empty-mask data", got, 0);
    end else if (wr) begin
      chk(lat == E_WP + 2, "R10 write latency", lat, E_WP + 2);
      chk(n_we == E_WP, "R7 strobe low cycles", n_we, E_WP);
      chk(n_oe == 0, "R7 output enable stays high", n_oe, 0);
      chk(n_sel == E_WP + 2, "R2 selected cycles in write", n_sel, E_WP + 2);
      chk(got == 16'h0, "R10 write response data", got, 0);
    end else begin
      chk(lat == E_RD + 1, "R10 read latency", lat, E_RD + 1);
      chk(n_oe == E_RD, "R5 output enable cycles", n_oe, E_RD);
      chk(n_we == 0, "R5 no write strobe in read", n_we, 0);
      chk(ce_at_rsp == 1'b1, "R9 unselected in turnaround", ce_at_rsp, 1);
      chk(got == exp, "R6 read data", got, exp);
    end
    chk(n_strb == 0, "R4 lane selects follow mask", n_strb, 0);
    chk(rdy_at_rsp == 1'b0, "R1 ready low while busy", rdy_at_rsp, 0);
  endtask

  // {write, mask, address, write data, expected read data}
  localparam int NV = 12;
  localparam logic [51:0] VEC [NV] = '{
    {1'b1, 2'b11, 17'h00010, 16'hA1B2, 16'h0000},
    {1'b0, 2'b11, 17'h00010, 16'h0000, 16'hA1B2},
    {1'b1, 2'b01, 17'h00010, 16'h33CC, 16'h0000},
    {1'b0, 2'b11, 17'h00010, 16'h0000, 16'hA1CC},
    {1'b1, 2'b10, 17'h00010, 16'h5566, 16'h0000},
    {1'b0, 2'b10, 17'h00010, 16'h0000, 16'h5500},
    {1'b0, 2'b01, 17'h00010, 16'h0000, 16'h00CC},
    {1'b1, 2'b11, 17'h1FFFF, 16'hFFFF, 16'h0000},
    {1'b0, 2'b11, 17'h1FFFF, 16'h0000, 16'hFFFF},
    {1'b1, 2'b11, 17'h00000, 16'h0001, 16'h0000},
    {1'b0, 2'b11, 17'h00000, 16'h0000, 16'h0001},
    {1'b0, 2'b11, 17'h1FFFF, 16'h0000, 16'hFFFF}
  };

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", checks);
    finish_run();
  end

  initial begin
    // R12: reset state
    repeat (3) @(negedge clk);
    chk(mem_ce_n && !mem_ce, "R12 unselected in reset", {mem_ce_n, mem_ce}, 2'b10);
    chk(mem_outen_n && mem_wstb_n, "R12 strobes high in reset", {mem_outen_n, mem_wstb_n}, 2'b11);
    chk(mem_hisel_n && mem_losel_n, "R12 lane selects high", {mem_hisel_n, mem_losel_n}, 2'b11);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rsp_valid, "R12 no response after reset", rsp_valid, 0);
    chk(req_ready, "R12 ready after reset", req_ready, 1);

    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i][51], VEC[i][50:49], VEC[i][48:32], VEC[i][31:16]);
      check_op(VEC[i][51], VEC[i][50:49], VEC[i][15:0]);
    end

    // R8: high-byte write keeps the low byte
    do_op(1'b1, 2'b10, 17'h00020, 16'h7700); check_op(1'b1, 2'b10, 0);
    do_op(1'b1, 2'b01, 17'h00020, 16'hEE11); check_op(1'b1, 2'b01, 0);
    do_op(1'b0, 2'b11, 17'h00020, 16'h0);
    chk(got == 16'h7711, "R8 lanes written independently", got, 16'h7711);

    // R3: empty mask, both directions
    do_op(1'b1, 2'b00, 17'h00020, 16'hDEAD); check_op(1'b1, 2'b00, 0);
    do_op(1'b0, 2'b00, 17'h00020, 16'h0);    check_op(1'b0, 2'b00, 0);
    do_op(1'b0, 2'b11, 17'h00020, 16'h0);
    chk(got == 16'h7711, "R3 empty-mask write left word intact", got, 16'h7711);

    // R9: ready returns one cycle after the turnaround cycle
    do_op(1'b0, 2'b11, 17'h00010, 16'h0);
    chk(!req_ready, "R9 ready low in turnaround", req_ready, 0);
    @(negedge clk);
    chk(req_ready, "R9 ready back after turnaround", req_ready, 1);
    chk(mem_outen_n && mem_ce_n, "R9 bus idle after read", {mem_outen_n, mem_ce_n}, 2'b11);

    // Mixed random traffic against the scoreboard
    for (int i = 0; i < 40; i++) begin
      logic wr; logic [1:0] be; logic [16:0] a; logic [15:0] d, e;
      wr = 1'($urandom % 2);
      be = 2'($urandom % 4);
      a  = 17'($urandom % 8);
      d  = 16'($urandom);
      e  = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
      e  = e & {{8{be[1]}}, {8{be[0]}}};
      do_op(wr, be, a, d);
      check_op(wr, be, e);
    end

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule